// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A synthesizable model of a single-port synchronous static memory. Every control, address and data input is taken on the rising clock edge. Read data leaves through an output register. A word is 18 bits wide and is split into two 9-bit lanes that can be written separately. The depth is a parameter, so the model stays small for simulation. A short two-bit counter produces the later addresses of a four-word burst, in either a linear or an interleaved order.

An access opens with one of two address strobes. The processor strobe always begins with a read, so a write through it needs a second clock. The controller strobe can write in the same clock that it opens the access. While no strobe is active, the advance input either steps the burst or holds it. Three chip enables select the device. The output enable acts without the clock. The bus direction is split into a data-in port, a data-out port and a drive-enable port.

Top module: `pbsram_core`

## Requirements
- R1: On a clock edge where a strobe is accepted, the device becomes selected only if `ce1_n`=0, `ce2`=1 and `ce3_n`=0. On any other accepted strobe it becomes deselected. The enables are ignored on edges without an accepted strobe.
- R2: `adsp_n`=0 is disregarded while `ce1_n`=1. If both strobes are low and `ce1_n`=0, only the processor strobe acts, and no write takes place in that clock.
- R3: A processor-strobe access is a read in its first clock, whatever the write inputs are. A write with the same address takes place on the following strobe-free clock.
- R4: A controller strobe with `adsp_n` high and active write inputs writes to the external address in that same clock. `adv_n` has no effect on that clock.
- R5: Lane enables: `gw_n`=0 writes both lanes. Otherwise lane k is written when `bwe_n`=0 and `bw_n[k]`=0. Lane 0 is data bits 8:0 and lane 1 is bits 17:9. Unwritten lanes keep their contents.
- R6: The word at an address accepted for reading at edge N is on `rdata_o` after edge N+1, with `rdata_oe_o`=1 when `oe_n`=0.
- R7: `rdata_oe_o` is 0 at any time `oe_n` is 1, without waiting for a clock.
- R8: After an edge at which a write is performed, `rdata_oe_o` is 0.
- R9: After an edge at which a strobe deselects the device, `rdata_oe_o` is 0, even while a read is in flight.
- R10: After the edge that moves the device from deselected to selected, `rdata_oe_o` stays 0 for that cycle, even with `oe_n`=0.
- R11: After a write, strobe-free read cycles leave `rdata_oe_o` at 0 until a strobe starts a new read.
- R12: On a strobe-free edge while selected, `adv_n`=0 steps the burst count and `adv_n`=1 holds it. The two low address bits are base+count mod 4 when `mode_lin`=1, and base XOR count when `mode_lin`=0. The upper bits keep the strobe address.
- R13: Reset clears every word to zero and leaves the outputs undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | External word address |
| ce1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Write of all lanes, active low |
| bwe_n | input | 1 | Lane write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| mode_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Registered read data |
| rdata_oe_o | output | 1 | Bus drive enable for `rdata_o` |

## Verification
The bench builds the block with its default parameters: ADDR_W=8, LANE_W=9 and LANES=2, which gives 256 words of two 9-bit lanes. With this small depth, random addresses confined to 32 words keep hitting the same four-word burst groups. That brings read-after-write through both strobes, partial lane overwrites, burst wraparound and suspend within reach in a few thousand cycles. The default depth also lets the bench check that reset cleared the array.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

    // Low two address bits of a burst beat, from the start offset and the beat count.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       linear);
        return linear ? (start + beat) : (start ^ beat);
    endfunction

endpackage

// File: rtl/pbsram_burst.sv
module pbsram_burst #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        beat_i,
    input  logic              linear_i,
    output logic [ADDR_W-1:0] addr_o
);
    import pbsram_pkg::*;

    assign addr_o = {base_i[ADDR_W-1:2], burst_low(base_i[1:0], beat_i, linear_i)};

endmodule

// File: rtl/pbsram_array.sv
module pbsram_array #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         we_i,
    input  logic [ADDR_W-1:0]        waddr_i,
    input  logic [LANES*LANE_W-1:0]  wdata_i,
    input  logic [ADDR_W-1:0]        raddr_i,
    output logic [LANES*LANE_W-1:0]  rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            end else if (we_i[g]) begin
                cells[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = cells[raddr_i];
    end

endmodule

// File: rtl/pbsram_core.sv
module pbsram_core #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     ce1_n,
    input  logic                     ce2,
    input  logic                     ce3_n,
    input  logic                     adsp_n,
    input  logic                     adsc_n,
    input  logic                     adv_n,
    input  logic                     gw_n,
    input  logic                     bwe_n,
    input  logic [LANES-1:0]         bw_n,
    input  logic                     oe_n,
    input  logic                     mode_lin,
    input  logic [LANES*LANE_W-1:0]  wdata_i,
    output logic [LANES*LANE_W-1:0]  rdata_o,
    output logic                     rdata_oe_o
);
    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;   // address taken with the last strobe
        logic [1:0]        beat;   // burst count
        logic              sel;    // device selected
        logic              wseen;  // a write since the last strobe
        logic              pend;   // a read must be presented at the next edge
        logic [ADDR_W-1:0] paddr;  // address of that read
        logic [WORD_W-1:0] dout;   // output register
        logic              drv;    // output drive allowed
    } state_t;

    state_t st_d, st_q;

    logic              sel_in, adsp_hit, adsc_hit, strobe, wr_req;
    logic [LANES-1:0]  lane_req, we;
    logic [ADDR_W-1:0] waddr, burst_addr;
    logic [1:0]        beat_nx;
    logic [WORD_W-1:0] rd_word;

    assign sel_in   = !ce1_n && ce2 && !ce3_n;
    assign adsp_hit = !adsp_n && !ce1_n;
    assign adsc_hit = !adsc_n && !adsp_hit;
    assign strobe   = adsp_hit || adsc_hit;
    assign lane_req = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bw_n : {LANES{1'b0}});
    assign wr_req   = |lane_req;
    assign beat_nx  = adv_n ? st_q.beat : st_q.beat + 2'd1;

    pbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .base_i   (st_q.base),
        .beat_i   (beat_nx),
        .linear_i (mode_lin),
        .addr_o   (burst_addr)
    );

    pbsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata_i),
        .raddr_i (st_q.paddr),
        .rdata_o (rd_word)
    );

    always_comb begin
        st_d  = st_q;
        we    = '0;
        waddr = addr_i;
        // Output stage: present the read accepted at the previous edge.
        st_d.drv  = st_q.pend;
        st_d.dout = st_q.pend ? rd_word : st_q.dout;
        if (strobe) begin
            st_d.base  = addr_i;
            st_d.beat  = '0;
            st_d.sel   = sel_in;
            st_d.wseen = 1'b0;
            if (!sel_in) begin
                st_d.pend = 1'b0;
                st_d.drv  = 1'b0;
            end else if (adsp_hit || !wr_req) begin
                st_d.pend  = 1'b1;
                st_d.paddr = addr_i;
            end else begin
                we         = lane_req;
                st_d.pend  = 1'b0;
                st_d.drv   = 1'b0;
                st_d.wseen = 1'b1;
            end
        end else if (st_q.sel) begin
            st_d.beat = beat_nx;
            if (wr_req) begin
                we         = lane_req;
                waddr      = burst_addr;
                st_d.pend  = 1'b0;
                st_d.drv   = 1'b0;
                st_d.wseen = 1'b1;
            end else begin
                st_d.pend  = !st_q.wseen;
                st_d.paddr = burst_addr;
            end
        end else begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o    = st_q.dout;
    assign rdata_oe_o = st_q.drv && !oe_n;

endmodule

// File: rtl/pbsram_core_chk.sv
module pbsram_core_chk #(
    parameter int WORD_W = 18,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              gw_n,
    input logic              bwe_n,
    input logic [LANES-1:0]  bw_n,
    input logic [WORD_W-1:0] rdata_o,
    input logic              rdata_oe_o,
    input logic              sel_q,
    input logic              pend_q
);
    logic sel_in, p_hit, c_hit, wr;
    assign sel_in = !ce1_n && ce2 && !ce3_n;
    assign p_hit  = !adsp_n && !ce1_n;
    assign c_hit  = !adsc_n && !p_hit;
    assign wr     = !gw_n || (!bwe_n && !(&bw_n));

    p_ctrl_write_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_hit && sel_in && wr) |=> !rdata_oe_o);

    p_deselect_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((p_hit || c_hit) && !sel_in) |=> !rdata_oe_o);

    p_first_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((p_hit || c_hit) && sel_in && !sel_q) |=> !rdata_oe_o);

    p_proc_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (p_hit && sel_in) |=> pend_q);

    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q |=> $stable(rdata_o));

endmodule

bind pbsram_core pbsram_core_chk #(.WORD_W(WORD_W), .LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .adsp_n     (adsp_n),
    .adsc_n     (adsc_n),
    .gw_n       (gw_n),
    .bwe_n      (bwe_n),
    .bw_n       (bw_n),
    .rdata_o    (rdata_o),
    .rdata_oe_o (rdata_oe_o),
    .sel_q      (st_q.sel),
    .pend_q     (st_q.pend)
);

// File: tb/pbsram_core_test.sv
`timescale 1ns/1ps
module pbsram_core_test;
    localparam int AW = 8;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic          gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0, mode_lin = 1'b1;
    logic [1:0]    bw_n = 2'b11;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_o;
    logic          rdata_oe_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference state
    logic [DW-1:0] m_mem [256];
    logic [AW-1:0] m_base, m_paddr;
    logic [1:0]    m_beat;
    logic          m_sel, m_wseen, m_pend, m_drv;
    logic [DW-1:0] m_dout;

    always #10 clk = ~clk;

    pbsram_core #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
        .mode_lin(mode_lin), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .rdata_oe_o(rdata_oe_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] low_of(input logic [1:0] s, input logic [1:0] b, input logic lin);
        return lin ? s + b : s ^ b;
    endfunction

    task automatic model_step();
        logic sel_in, ph, ch, ld, wr;
        logic [1:0] lanes;
        logic [DW-1:0] rd;
        logic [AW-1:0] a;
        sel_in = !ce1_n && ce2 && !ce3_n;
        ph = !adsp_n && !ce1_n;
        ch = !adsc_n && !ph;
        ld = ph || ch;
        lanes = !gw_n ? 2'b11 : (!bwe_n ? ~bw_n : 2'b00);
        wr = lanes != 2'b00;
        rd = m_mem[m_paddr];
        m_drv = m_pend;
        if (m_pend) m_dout = rd;
        a = addr_i;
        if (ld) begin
            m_base = addr_i; m_beat = 2'd0; m_sel = sel_in; m_wseen = 1'b0;
            if (!sel_in) begin m_pend = 0; m_drv = 0; end
            else if (ph || !wr) begin m_pend = 1; m_paddr = addr_i; end
            else begin m_pend = 0; m_drv = 0; m_wseen = 1; end
        end else if (m_sel) begin
            if (!adv_n) m_beat = m_beat + 2'd1;
            a = {m_base[AW-1:2], low_of(m_base[1:0], m_beat, mode_lin)};
            if (wr) begin m_pend = 0; m_drv = 0; m_wseen = 1; end
            else begin m_pend = !m_wseen; m_paddr = a; end
        end else begin
            m_pend = 0;
        end
        if (wr && ((ld && sel_in && ch) || (!ld && m_sel))) begin
            if (lanes[0]) m_mem[a][8:0]  = wdata_i[8:0];
            if (lanes[1]) m_mem[a][17:9] = wdata_i[17:9];
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R8 drive vs reference", {31'd0, rdata_oe_o}, {31'd0, m_drv && !oe_n});
        if (m_drv && !oe_n) chk("R6 data vs reference", {14'd0, rdata_o}, {14'd0, m_dout});
    endtask

    task automatic idle();
        adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 2'b11;
        oe_n = 0; ce1_n = 0; ce2 = 1; ce3_n = 0;
    endtask

    task automatic ctrl_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle(); adsc_n = 0; addr_i = a; wdata_i = d; gw_n = 0; adv_n = 0; cyc();
    endtask

    task automatic proc_read(input logic [AW-1:0] a);
        idle(); adsp_n = 0; addr_i = a; cyc();
    endtask

    task automatic expect_out(input string tag, input logic oe, input logic [DW-1:0] d);
        chk(tag, {31'd0, rdata_oe_o}, {31'd0, oe});
        if (oe) chk(tag, {14'd0, rdata_o}, {14'd0, d});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) m_mem[i] = '0;
        m_base = '0; m_paddr = '0; m_beat = '0; m_sel = 0; m_wseen = 0;
        m_pend = 0; m_drv = 0; m_dout = '0;
        void'($urandom(32'h0000_5eed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R13: no drive after reset, array reads zero
        expect_out("R13 reset drive", 1'b0, '0);
        proc_read(8'h07); idle(); cyc();
        expect_out("R13 cleared word", 1'b1, '0);

        // R6 basic write then read
        ctrl_write(8'h10, 18'h2AB55);
        proc_read(8'h10); idle(); cyc();
        expect_out("R6 read latency", 1'b1, 18'h2AB55);
        // R7 output enable without clock
        oe_n = 1; #1;
        chk("R7 oe_n high", {31'd0, rdata_oe_o}, 32'd0);
        oe_n = 0; #1;
        chk("R7 oe_n low", {31'd0, rdata_oe_o}, 32'd1);

        // R5 lane 0 only; R8 tristate after write
        idle(); adsc_n = 0; addr_i = 8'h10; wdata_i = 18'h00011; bwe_n = 0; bw_n = 2'b10; cyc();
        expect_out("R8 after write", 1'b0, '0);
        proc_read(8'h10); idle(); cyc();
        expect_out("R5 lane merge", 1'b1, 18'h2AA11);

        // R3 processor strobe: first clock reads, write lands next clock
        idle(); adsp_n = 0; addr_i = 8'h20; gw_n = 0; wdata_i = 18'h3FFFF; cyc();
        idle(); gw_n = 0; wdata_i = 18'h12345; cyc();
        proc_read(8'h20); idle(); cyc();
        expect_out("R3 second-clock write", 1'b1, 18'h12345);
        idle(); adsp_n = 0; addr_i = 8'h24; gw_n = 0; wdata_i = 18'h3FFFF; cyc();
        idle(); cyc();
        expect_out("R3 first clock is read", 1'b1, 18'h00000);

        // R2 processor strobe gated by ce1_n
        idle(); ce1_n = 1; adsp_n = 0; addr_i = 8'h10; cyc();
        idle(); cyc();
        expect_out("R2 strobe ignored", 1'b1, 18'h00000);
        // R2 both strobes: processor wins, no write
        idle(); adsp_n = 0; adsc_n = 0; addr_i = 8'h30; gw_n = 0; wdata_i = 18'h00005; cyc();
        idle(); cyc();
        expect_out("R2 processor priority", 1'b1, 18'h00000);

        // R9 deselect, R1 decode, R10 first-cycle mask
        idle(); adsc_n = 0; ce2 = 0; cyc();
        expect_out("R9 deselect hiz", 1'b0, '0);
        idle(); cyc();
        expect_out("R1 stays deselected", 1'b0, '0);
        proc_read(8'h10);
        expect_out("R10 first cycle masked", 1'b0, '0);
        idle(); cyc();
        expect_out("R6 after reselect", 1'b1, 18'h2AA11);

        // R11 stays off after write until new strobe read
        ctrl_write(8'h10, 18'h0F0F0);
        idle(); cyc();
        expect_out("R11 continue after write", 1'b0, '0);
        cyc();
        expect_out("R11 still off", 1'b0, '0);
        proc_read(8'h10); idle(); cyc();
        expect_out("R11 new strobe read", 1'b1, 18'h0F0F0);

        // R4 writes with advance low land on the external address
        for (int i = 0; i < 4; i++) ctrl_write(8'h40 + 8'(i), 18'h00100 + 18'(i));
        idle(); adsc_n = 0; addr_i = 8'h43; cyc();
        idle(); cyc();
        expect_out("R4 controller write address", 1'b1, 18'h00103);

        // R12 linear burst from offset 2 with suspend and wrap
        mode_lin = 1; proc_read(8'h42);
        idle(); adv_n = 0; cyc(); expect_out("R12 linear beat0", 1'b1, 18'h00102);
        cyc(); expect_out("R12 linear beat1", 1'b1, 18'h00103);
        cyc(); expect_out("R12 linear wrap", 1'b1, 18'h00100);
        adv_n = 1; cyc(); expect_out("R12 linear beat3", 1'b1, 18'h00101);
        cyc(); expect_out("R12 suspend holds", 1'b1, 18'h00101);
        adv_n = 0; cyc(); expect_out("R12 resume", 1'b1, 18'h00101);
        cyc(); expect_out("R12 full wrap", 1'b1, 18'h00102);
        // R12 interleaved from offset 1
        mode_lin = 0; proc_read(8'h41);
        idle(); adv_n = 0; cyc(); expect_out("R12 ilv beat0", 1'b1, 18'h00101);
        cyc(); expect_out("R12 ilv beat1", 1'b1, 18'h00100);
        cyc(); expect_out("R12 ilv beat2", 1'b1, 18'h00103);
        cyc(); expect_out("R12 ilv beat3", 1'b1, 18'h00102);

        // constrained random against the reference
        for (int n = 0; n < 4000; n++) begin
            if (n % 200 == 0) mode_lin = 1'($urandom % 2);
            adsp_n  = ($urandom % 5) != 0;
            adsc_n  = ($urandom % 4) != 0;
            ce1_n   = ($urandom % 8) == 0;
            ce2     = ($urandom % 10) != 0;
            ce3_n   = ($urandom % 10) == 0;
            adv_n   = 1'($urandom % 2);
            gw_n    = ($urandom % 6) != 0;
            bwe_n   = ($urandom % 3) != 0;
            bw_n    = 2'($urandom);
            oe_n    = ($urandom % 8) == 0;
            addr_i  = 8'($urandom % 32);
            wdata_i = 18'($urandom);
            cyc();
        end
        finish_run();
    end
endmodule